// File: doc/BRIEF.md
# Pipeline Stall Interlock Controller

This block controls hazards for a five-stage in-order pipeline that has no operand forwarding. The stages, in order, are fetch (IF), decode/register read (DC), execute (EX), memory (MEM) and write-back (WB). Instruction descriptors enter through a valid/ready stream port. Each descriptor carries a tag, a branch flag, a register-write flag with its destination, and two source registers. The block keeps its own copy of the stage occupancy and resolves every conflict by holding instructions.

Read-after-write hazards are handled conservatively. An instruction in decode that reads a register still pending in EX, MEM or WB stays in decode. It leaves only in the cycle after its producer has left write-back. While it waits, fetch and decode hold their contents and EX receives an empty slot. Branches are also handled conservatively. Once a branch is in the pipe, no new instruction is accepted until that branch sits in write-back. This applies whether or not the branch is taken.

Back-pressure follows the usual stream rules. A descriptor transfers on a clock edge where both `in_valid` and `in_ready` are high. While `in_valid` is high and `in_ready` is low, the source must hold the descriptor stable. `in_ready` does not depend on `in_valid`. A per-stage trace port reports occupancy and tags for checking.

Top module: `stall_interlock`

## Requirements
- R1: While reset is asserted and right after it, every trace valid bit is 0, `in_ready` is 1, and `hold_if`, `hold_rf` and `bubble_ex` are 0.
- R2: A descriptor accepted on an edge (`in_valid` and `in_ready` both high) shows in the IF trace slot with its tag in the next cycle. With no stalls, each instruction moves one stage per cycle. Trace bit i (0=IF, 1=DC, 2=EX, 3=MEM, 4=WB) marks occupancy, and the tag of stage i is at `trc_tag[i*TAG_W +: TAG_W]`.
- R3: An instruction in DC whose `src_a` or `src_b` equals the destination of a valid, writing instruction in EX, MEM or WB stays in DC. It moves to EX in the cycle after its last such producer has been in WB.
- R4: In a stalled decode cycle, `hold_rf` and `bubble_ex` are 1. The DC and IF contents stay in place, and EX is empty in the next cycle. Instructions in EX and MEM still advance.
- R5: Register 0 never causes a stall, whether it appears as a source or as a destination.
- R6: `in_ready` is 0 while a branch occupies IF, DC or EX. The next instruction therefore reaches IF in the same cycle the branch reaches WB. There is no taken/not-taken input, so a not-taken branch stalls just as long.
- R7: Only the write flag of an older instruction decides whether it is a producer. The instruction kind (load or ALU) does not matter, and an older instruction with write flag 0 causes no stall even if its destination field matches.
- R8: A branch that is itself data-stalled in DC keeps fetch blocked. The block releases only when both conditions have cleared.
- R9: `hold_if` is always the complement of `in_ready`. It is 1 when IF is occupied and decode is stalled, or when a branch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_tag | input | TAG_W | Instruction tag for the trace |
| in_branch | input | 1 | Instruction is a branch |
| in_wr | input | 1 | Instruction writes a register |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| hold_if | output | 1 | Fetch must not advance |
| hold_rf | output | 1 | Decode holds its instruction |
| bubble_ex | output | 1 | Empty slot inserted into EX |
| trc_valid | output | 5 | Stage occupancy, bit 0 = IF to bit 4 = WB |
| trc_tag | output | 5*TAG_W | Stage tags, packed by stage index |

## Verification
The main test is a six-instruction program: a load into t1, a branch on t1, an independent add-immediate, an add reading t1, a load through t1 and an add reading t1. Every cycle's occupancy is compared with a precomputed table. This program separates the branch window from the data stall, and it catches a branch that is data-stalled while fetch is blocked. It also catches back-to-back dependences where the younger instruction waits in IF. Short pairs then tell real dependences apart from false ones. A match on `src_b` must stall. A register-0 destination and a non-writing producer must not stall. Each case is identified by the cycle the consumer reaches EX.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int ST_FE   = 0;
  localparam int ST_DC   = 1;
  localparam int ST_EX   = 2;
  localparam int ST_MEM  = 3;
  localparam int ST_WB   = 4;
  localparam int NUM_STG = 5;
  // stages that can still hold a pending register write seen by decode
  localparam int NUM_PROD = NUM_STG - ST_EX;
  // stages in which a branch blocks fetch (up to and including EX)
  localparam int NUM_BRW  = ST_EX + 1;
endpackage

// File: rtl/ilk_raw_detect.sv
module ilk_raw_detect #(
  parameter int REG_W = 5,
  parameter int NPROD = 3
) (
  input  logic                   dc_valid,
  input  logic [REG_W-1:0]       src_a,
  input  logic [REG_W-1:0]       src_b,
  input  logic [NPROD-1:0]       prod_live,
  input  logic [NPROD*REG_W-1:0] prod_dst,
  output logic                   stall
);
  logic [NPROD-1:0] hit;

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    logic [REG_W-1:0] d;
    assign d      = prod_dst[g*REG_W +: REG_W];
    // register zero never holds a pending value
    assign hit[g] = prod_live[g] && (d != '0) && ((d == src_a) || (d == src_b));
  end

  assign stall = dc_valid && (|hit);
endmodule

// File: rtl/ilk_fetch_gate.sv
module ilk_fetch_gate #(
  parameter int NWATCH = 3
) (
  input  logic [NWATCH-1:0] br_live,
  input  logic              fe_valid,
  input  logic              dc_stall,
  output logic              in_ready,
  output logic              hold_if
);
  logic br_block;
  assign br_block = |br_live;
  assign hold_if  = br_block || (fe_valid && dc_stall);
  assign in_ready = !hold_if;
endmodule

// File: rtl/stall_interlock.sv
module stall_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic                     in_branch,
  input  logic                     in_wr,
  input  logic [REG_W-1:0]         in_dst,
  input  logic [REG_W-1:0]         in_src_a,
  input  logic [REG_W-1:0]         in_src_b,
  output logic                     hold_if,
  output logic                     hold_rf,
  output logic                     bubble_ex,
  output logic [NUM_STG-1:0]       trc_valid,
  output logic [NUM_STG*TAG_W-1:0] trc_tag
);
  logic [NUM_STG-1:0] v_q;
  logic [NUM_STG-1:0] wr_q;
  logic [ST_EX:0]     br_q;
  logic [REG_W-1:0]   dst_q [NUM_STG];
  logic [TAG_W-1:0]   tag_q [NUM_STG];
  logic [REG_W-1:0]   fe_sa, fe_sb, dc_sa, dc_sb;

  logic                    dc_stall;
  logic                    accept;
  logic [NUM_PROD-1:0]       prod_live;
  logic [NUM_PROD*REG_W-1:0] prod_dst;
  logic [NUM_BRW-1:0]        br_live;

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_prod
    assign prod_live[g]              = v_q[ST_EX+g] && wr_q[ST_EX+g];
    assign prod_dst[g*REG_W +: REG_W] = dst_q[ST_EX+g];
  end

  for (genvar g = 0; g < NUM_BRW; g++) begin : g_brw
    assign br_live[g] = v_q[g] && br_q[g];
  end

  ilk_raw_detect #(.REG_W(REG_W), .NPROD(NUM_PROD)) u_raw (
    .dc_valid (v_q[ST_DC]),
    .src_a    (dc_sa),
    .src_b    (dc_sb),
    .prod_live(prod_live),
    .prod_dst (prod_dst),
    .stall    (dc_stall)
  );

  ilk_fetch_gate #(.NWATCH(NUM_BRW)) u_gate (
    .br_live (br_live),
    .fe_valid(v_q[ST_FE]),
    .dc_stall(dc_stall),
    .in_ready(in_ready),
    .hold_if (hold_if)
  );

  assign accept    = in_valid && in_ready;
  assign hold_rf   = dc_stall;
  assign bubble_ex = dc_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      wr_q  <= '0;
      br_q  <= '0;
      fe_sa <= '0;
      fe_sb <= '0;
      dc_sa <= '0;
      dc_sb <= '0;
      for (int i = 0; i < NUM_STG; i++) begin
        dst_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else begin
      // fetch slot
      if (accept) begin
        v_q[ST_FE]   <= 1'b1;
        br_q[ST_FE]  <= in_branch;
        wr_q[ST_FE]  <= in_wr;
        dst_q[ST_FE] <= in_dst;
        tag_q[ST_FE] <= in_tag;
        fe_sa        <= in_src_a;
        fe_sb        <= in_src_b;
      end else if (!dc_stall) begin
        v_q[ST_FE] <= 1'b0;
      end
      // decode slot holds while stalled
      if (!dc_stall) begin
        v_q[ST_DC]   <= v_q[ST_FE];
        br_q[ST_DC]  <= br_q[ST_FE];
        wr_q[ST_DC]  <= wr_q[ST_FE];
        dst_q[ST_DC] <= dst_q[ST_FE];
        tag_q[ST_DC] <= tag_q[ST_FE];
        dc_sa        <= fe_sa;
        dc_sb        <= fe_sb;
      end
      // execute slot takes a bubble while decode is stalled
      if (dc_stall) begin
        v_q[ST_EX] <= 1'b0;
      end else begin
        v_q[ST_EX]   <= v_q[ST_DC];
        br_q[ST_EX]  <= br_q[ST_DC];
        wr_q[ST_EX]  <= wr_q[ST_DC];
        dst_q[ST_EX] <= dst_q[ST_DC];
        tag_q[ST_EX] <= tag_q[ST_DC];
      end
      // tail always advances
      for (int i = ST_MEM; i < NUM_STG; i++) begin
        v_q[i]   <= v_q[i-1];
        wr_q[i]  <= wr_q[i-1];
        dst_q[i] <= dst_q[i-1];
        tag_q[i] <= tag_q[i-1];
      end
    end
  end

  for (genvar s = 0; s < NUM_STG; s++) begin : g_trc
    assign trc_valid[s]               = v_q[s];
    assign trc_tag[s*TAG_W +: TAG_W]  = tag_q[s];
  end
endmodule

// File: rtl/stall_interlock_chk.sv
module stall_interlock_chk #(
  parameter int TAG_W = 4,
  parameter int NSTG  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [TAG_W-1:0]      in_tag,
  input logic                  hold_rf,
  input logic                  bubble_ex,
  input logic [NSTG-1:0]       trc_valid,
  input logic [NSTG*TAG_W-1:0] trc_tag
);
  logic [TAG_W-1:0] t_fe, t_dc, t_ex, t_mem, t_wb;
  assign t_fe  = trc_tag[0*TAG_W +: TAG_W];
  assign t_dc  = trc_tag[1*TAG_W +: TAG_W];
  assign t_ex  = trc_tag[2*TAG_W +: TAG_W];
  assign t_mem = trc_tag[3*TAG_W +: TAG_W];
  assign t_wb  = trc_tag[4*TAG_W +: TAG_W];

  // R1
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> (trc_valid == '0));

  // R2
  fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (trc_valid[0] && t_fe == $past(in_tag)));

  // R2
  dc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid[1] && !hold_rf) |=> (trc_valid[2] && t_ex == $past(t_dc)));

  // R4
  dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rf |=> (trc_valid[1] && $stable(t_dc)));

  // R4
  ex_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |=> !trc_valid[2]);

  // R4
  tail_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid[2] |=> (trc_valid[3] && t_mem == $past(t_ex)));

  // R4
  wb_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid[3] |=> (trc_valid[4] && t_wb == $past(t_mem)));
endmodule

bind stall_interlock stall_interlock_chk #(.TAG_W(TAG_W), .NSTG(ilk_pkg::NUM_STG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_tag   (in_tag),
  .hold_rf  (hold_rf),
  .bubble_ex(bubble_ex),
  .trc_valid(trc_valid),
  .trc_tag  (trc_tag)
);

// File: tb/tb_stall_interlock.sv
module tb_stall_interlock;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;
  localparam int TAG_W = 4;
  localparam int NSTG  = 5;

  // expected occupancy per cycle, nibbles IF,DC,EX,MEM,WB (0 = empty)
  localparam logic [19:0] EXP_TRACE [22] = '{
    20'h10000, 20'h21000, 20'h02100, 20'h02010, 20'h02001, 20'h02000,
    20'h00200, 20'h00020, 20'h30002, 20'h43000, 20'h54300, 20'h65430,
    20'h65043, 20'h65004, 20'h65000, 20'h06500, 20'h06050, 20'h06005,
    20'h06000, 20'h00600, 20'h00060, 20'h00006
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TAG_W-1:0] in_tag = '0;
  logic in_branch = 1'b0;
  logic in_wr = 1'b0;
  logic [REG_W-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic hold_if, hold_rf, bubble_ex;
  logic [NSTG-1:0] trc_valid;
  logic [NSTG*TAG_W-1:0] trc_tag;

  int n_cmp = 0;
  int n_bad = 0;

  logic             sq_br  [8];
  logic             sq_wr  [8];
  logic [REG_W-1:0] sq_dst [8];
  logic [REG_W-1:0] sq_sa  [8];
  logic [REG_W-1:0] sq_sb  [8];

  logic [19:0] obs_tr  [32];
  logic        obs_rdy [32];
  logic        obs_hif [32];
  logic        obs_hrf [32];
  logic        obs_bub [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_interlock #(.REG_W(REG_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_branch(in_branch), .in_wr(in_wr), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .hold_if(hold_if),
    .hold_rf(hold_rf), .bubble_ex(bubble_ex), .trc_valid(trc_valid),
    .trc_tag(trc_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] pack_trace();
    logic [19:0] r = '0;
    for (int s = 0; s < NSTG; s++)
      if (trc_valid[s]) r[(4-s)*4 +: 4] = trc_tag[s*TAG_W +: TAG_W];
    return r;
  endfunction

  task automatic drive(input int idx, input int n);
    if (idx < n) begin
      in_valid = 1'b1; in_tag = TAG_W'(idx + 1); in_branch = sq_br[idx];
      in_wr = sq_wr[idx]; in_dst = sq_dst[idx];
      in_src_a = sq_sa[idx]; in_src_b = sq_sb[idx];
    end else begin
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(trc_valid == '0, "R1", "trace valid", trc_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk({hold_if, hold_rf, bubble_ex} == 3'b000, "R1", "holds",
        {hold_if, hold_rf, bubble_ex}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_seq(input int n, input int ncyc);
    int idx = 0;
    bit acc;
    do_reset();
    drive(idx, n);
    for (int c = 0; c < ncyc; c++) begin
      acc = in_valid && in_ready;
      @(posedge clk);
      @(negedge clk);
      obs_tr[c]  = pack_trace();
      obs_rdy[c] = in_ready;
      obs_hif[c] = hold_if;
      obs_hrf[c] = hold_rf;
      obs_bub[c] = bubble_ex;
      if (acc) idx++;
      drive(idx, n);
    end
  endtask

  task automatic set_ins(input int k, input logic br, input logic wr,
                         input int dst, input int sa, input int sb);
    sq_br[k] = br; sq_wr[k] = wr; sq_dst[k] = REG_W'(dst);
    sq_sa[k] = REG_W'(sa); sq_sb[k] = REG_W'(sb);
  endtask

  // two-instruction case: returns the first cycle the second one is in EX
  task automatic run_pair(input logic wr0, input int dst0, input int sa1,
                          input int sb1, output int ex_cyc);
    set_ins(0, 1'b0, wr0, dst0, 3, 0);
    set_ins(1, 1'b0, 1'b1, 8, sa1, sb1);
    run_seq(2, 12);
    ex_cyc = -1;
    for (int c = 11; c >= 0; c--)
      if (obs_tr[c][11:8] == 4'h2) ex_cyc = c;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int ex_c;
    logic exp_h;
    // program: t1=9, a0=4, t3=11, v0=2
    set_ins(0, 1'b0, 1'b1, 9, 4, 0);   // load t1
    set_ins(1, 1'b1, 1'b0, 0, 9, 0);   // branch on t1
    set_ins(2, 1'b0, 1'b1, 4, 4, 0);   // add-immediate a0
    set_ins(3, 1'b0, 1'b1, 9, 9, 11);  // add t1 = t1 + t3
    set_ins(4, 1'b0, 1'b1, 9, 9, 0);   // load through t1
    set_ins(5, 1'b0, 1'b1, 2, 2, 9);   // add v0 = v0 + t1
    run_seq(6, 22);

    for (int c = 0; c < 22; c++) begin
      // R2 R3 R6 per-cycle occupancy against table
      chk(obs_tr[c] == EXP_TRACE[c], "R3", $sformatf("trace cycle %0d", c),
          obs_tr[c], EXP_TRACE[c]);
      exp_h = (c < 21) && (EXP_TRACE[c][15:12] != 4'h0) &&
              (EXP_TRACE[c+1][15:12] == EXP_TRACE[c][15:12]);
      // R4 decode hold and bubble
      chk(obs_hrf[c] == exp_h, "R4", $sformatf("hold_rf cycle %0d", c), obs_hrf[c], exp_h);
      chk(obs_bub[c] == exp_h, "R4", $sformatf("bubble_ex cycle %0d", c), obs_bub[c], exp_h);
      // R9 hold_if mirrors in_ready
      chk(obs_hif[c] == !obs_rdy[c], "R9", $sformatf("hold_if cycle %0d", c),
          obs_hif[c], !obs_rdy[c]);
    end
    for (int c = 0; c < 9; c++) begin
      // R6 branch window, R8 while the branch is also data-stalled (cycles 2..4)
      chk(obs_rdy[c] == !(c >= 1 && c <= 6), (c >= 2 && c <= 4) ? "R8" : "R6",
          $sformatf("in_ready cycle %0d", c), obs_rdy[c], !(c >= 1 && c <= 6));
    end
    // R9 IF occupied behind a stalled decode
    chk(obs_hif[12] == 1'b1, "R9", "hold_if with IF held", obs_hif[12], 1);

    // R2 independent pair flows back to back
    run_pair(1'b1, 5, 6, 7, ex_c);
    chk(ex_c == 3, "R2", "independent EX cycle", ex_c, 3);
    // R3 dependence through second source
    run_pair(1'b1, 7, 1, 7, ex_c);
    chk(ex_c == 6, "R3", "src_b dependence EX cycle", ex_c, 6);
    // R3 dependence through first source
    run_pair(1'b1, 7, 7, 1, ex_c);
    chk(ex_c == 6, "R3", "src_a dependence EX cycle", ex_c, 6);
    // R5 register zero destination and source
    run_pair(1'b1, 0, 0, 0, ex_c);
    chk(ex_c == 3, "R5", "register 0 EX cycle", ex_c, 3);
    // R7 non-writing older instruction with matching field
    run_pair(1'b0, 5, 5, 0, ex_c);
    chk(ex_c == 3, "R7", "non-writer EX cycle", ex_c, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule